// File: doc/BRIEF.md
# Flash Program Beat Collector

This block sits between a flash controller and a flash array's write port and turns a stream of single-word program beats into one program operation. Each beat arrives on a request line together with its data word, its program type and, for the first beat, the start address. Every beat that is taken is acknowledged in the cycle it is offered. Beats are stored in an internal burst buffer of up to `BURST_MAX` words (16 by default).

A burst closes in one of two ways. Either the beat carrying the last-beat flag arrives, or the buffer fills at its sixteenth beat. The block then runs a program countdown whose length depends on the program type: a short one for normal programming and a longer one for repair programming. After the countdown it writes the buffered words to consecutive array addresses, one per cycle. Each write can only clear bits, because the new word is ANDed into the stored one. A single done pulse then covers the whole burst.

After reset the block spends a fixed number of cycles initialising and takes no beats during that time. A constant output tells callers which program types are supported. A caller must never issue a type that is not marked available. The block does not check for this.

Top module: `prog_burst_collector`

## Requirements
- R1: After reset, `init_busy` is high for exactly `INIT_CYC` (8) cycles. While it is high, `ack` stays low even when `prog_req` is held high.
- R2: Once initialisation is over and no burst is in progress, `ack` is high in the same cycle as `prog_req`. The beat is taken at that clock edge.
- R3: A burst ends on the beat that carries `prog_last`, or on its `BURST_MAX`-th (16th) beat, whichever comes first. The beat after a closed burst starts a new burst. The start address is taken from the first beat of a burst only; `prog_addr` on later beats has no effect.
- R4: From the clock edge that takes the final beat of a burst until the cycle after `done`, `ack` stays low whatever `prog_req` does.
- R5: `done` is a one-cycle pulse. With the final beat taken at edge A, `done` is high in the cycle after edge A+T+n, where n is the number of beats in the burst. T is `NORM_CYC` (20) when the first beat's `prog_type` is 0 (normal) and `REPAIR_CYC` (48) when it is 1 (repair). `prog_type` on later beats is ignored.
- R6: Between the countdown and `done`, the block asserts `arr_we` for n consecutive cycles. The writes go to addresses start, start+1, ... in beat order, and each write data is `arr_rdata & beat word`, so a program only clears bits.
- R7: `type_avail` equals the `TYPES_AVAIL` parameter at all times (default 2'b11). Bit 0 marks normal and bit 1 marks repair.
- R8: Each burst produces exactly one `done`. No `done` is produced per beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_req | input | 1 | A program beat is offered |
| prog_type | input | 1 | Program type: 0 normal, 1 repair (first beat decides) |
| prog_data | input | WORD_W | Word to program for this beat |
| prog_last | input | 1 | This beat is the final one of the burst |
| prog_addr | input | ADDR_W | Start address, used on the first beat |
| ack | output | 1 | Beat taken this cycle |
| done | output | 1 | One-cycle pulse when the burst's program has finished |
| init_busy | output | 1 | Initialisation is running |
| type_avail | output | 2 | Supported program types (bit 0 normal, bit 1 repair) |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array address for read and write |
| arr_wdata | output | WORD_W | Word written to the array |
| arr_rdata | input | WORD_W | Current array content at `arr_addr` |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose. The first pair is the last-beat flag and the buffer limit: a sixteen-beat burst with `prog_last` on its final beat must close exactly once and behave like a sixteen-beat burst without the flag. The second pair is a pending request and the completion of the previous burst. The bench holds `prog_req` high through the countdown, the writes and the done cycle. It then checks that `ack` stays low in all of them, that `done` lands on the cycle computed from the type and the beat count, and that the array model holds the ANDed words afterwards. Random bursts of random length and type, with junk type and address on later beats, are mixed with these directed cases.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_COLLECT,
    ST_PROG,
    ST_WRITE,
    ST_DONE
  } pbc_state_e;

  localparam logic TYPE_NORMAL = 1'b0;
  localparam logic TYPE_REPAIR = 1'b1;

  // Countdown length for one program operation of the given type.
  function automatic int unsigned prog_time(input logic ptype,
                                            input int unsigned t_norm,
                                            input int unsigned t_rep);
    return (ptype == TYPE_REPAIR) ? t_rep : t_norm;
  endfunction

  // Larger of two counts, used to size counters.
  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbc_buf.sv
module pbc_buf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/pbc_timer.sv
module pbc_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire = (cnt_q == CNT_W'(1));

  // R5: a running countdown moves down by one each cycle
  assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/prog_burst_collector.sv
module prog_burst_collector
  import pbc_pkg::*;
#(
  parameter int          WORD_W      = 16,
  parameter int          ADDR_W      = 8,
  parameter int          BURST_MAX   = 16,
  parameter int          NORM_CYC    = 20,
  parameter int          REPAIR_CYC  = 48,
  parameter int          INIT_CYC    = 8,
  parameter logic [1:0]  TYPES_AVAIL = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic              prog_type,
  input  logic [WORD_W-1:0] prog_data,
  input  logic              prog_last,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              ack,
  output logic              done,
  output logic              init_busy,
  output logic [1:0]        type_avail,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [WORD_W-1:0] arr_wdata,
  input  logic [WORD_W-1:0] arr_rdata
);

  localparam int CNT_W  = $clog2(BURST_MAX + 1);
  localparam int IDX_W  = $clog2(BURST_MAX);
  localparam int TMR_W  = $clog2(max2(NORM_CYC, REPAIR_CYC) + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);

  pbc_state_e        state_q;
  logic [INIT_W-1:0] init_cnt_q;
  logic [CNT_W-1:0]  beat_cnt_q;
  logic [CNT_W-1:0]  nwords_q;
  logic [ADDR_W-1:0] base_q;
  logic              type_q;
  logic [IDX_W-1:0]  widx_q;

  // Named internal events
  logic              collecting;
  logic              beat_take;
  logic              first_beat;
  logic              eff_type;
  logic              burst_end;
  logic              tmr_expire;
  logic              write_last;
  logic [TMR_W-1:0]  tmr_val;
  logic [WORD_W-1:0] buf_word;

  assign collecting = (state_q == ST_COLLECT);
  assign beat_take  = prog_req && collecting;
  assign first_beat = (beat_cnt_q == '0);
  assign eff_type   = first_beat ? prog_type : type_q;
  assign burst_end  = beat_take &&
                      (prog_last || (beat_cnt_q == CNT_W'(BURST_MAX - 1)));
  assign tmr_val    = TMR_W'(prog_time(eff_type, NORM_CYC, REPAIR_CYC));
  assign write_last = ((CNT_W'(widx_q) + CNT_W'(1)) == nwords_q);

  pbc_buf #(.WORD_W(WORD_W), .DEPTH(BURST_MAX)) u_buf (
    .clk     (clk),
    .wr_en   (beat_take),
    .wr_idx  (beat_cnt_q[IDX_W-1:0]),
    .wr_data (prog_data),
    .rd_idx  (widx_q),
    .rd_data (buf_word)
  );

  pbc_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (burst_end),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_INIT;
      init_cnt_q <= '0;
      beat_cnt_q <= '0;
      nwords_q   <= '0;
      base_q     <= '0;
      type_q     <= TYPE_NORMAL;
      widx_q     <= '0;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          if (init_cnt_q == INIT_W'(INIT_CYC - 1)) state_q <= ST_COLLECT;
          else init_cnt_q <= init_cnt_q + INIT_W'(1);
        end
        ST_COLLECT: begin
          if (beat_take) begin
            if (first_beat) begin
              base_q <= prog_addr;
              type_q <= prog_type;
            end
            if (burst_end) begin
              nwords_q   <= beat_cnt_q + CNT_W'(1);
              beat_cnt_q <= '0;
              state_q    <= ST_PROG;
            end else begin
              beat_cnt_q <= beat_cnt_q + CNT_W'(1);
            end
          end
        end
        ST_PROG: begin
          if (tmr_expire) begin
            widx_q  <= '0;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (write_last) state_q <= ST_DONE;
          else widx_q <= widx_q + IDX_W'(1);
        end
        ST_DONE: state_q <= ST_COLLECT;
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign ack        = beat_take;
  assign done       = (state_q == ST_DONE);
  assign init_busy  = (state_q == ST_INIT);
  assign type_avail = TYPES_AVAIL;
  assign arr_we     = (state_q == ST_WRITE);
  assign arr_addr   = base_q + ADDR_W'(widx_q);
  assign arr_wdata  = arr_rdata & buf_word;

  // R1: nothing is taken while initialising
  assert_no_ack_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !ack);

  // R3: the beat counter never passes the burst limit
  assert_burst_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt_q <= CNT_W'(BURST_MAX - 1));

  // R4: the edge that closes a burst is followed by silence on ack
  assert_quiet_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (!ack && !done));

  // R5: done lasts a single cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: writing starts right after the countdown ends
  assert_write_after_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && tmr_expire) |=> arr_we);

  // R6: a write never sets a bit that was clear in the array
  assert_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ((arr_wdata & ~arr_rdata) == '0));

  // R8: done follows the last write, never a beat
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(arr_we));

endmodule

// File: tb/prog_burst_collector_tb.sv
`timescale 1ns/1ps
module prog_burst_collector_tb;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 8;
  localparam int BMAX   = 16;
  localparam int T_NORM = 20;
  localparam int T_REP  = 48;
  localparam int T_INIT = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              prog_req, prog_type, prog_last;
  logic [WORD_W-1:0] prog_data;
  logic [ADDR_W-1:0] prog_addr;
  logic              ack, done, init_busy, arr_we;
  logic [1:0]        type_avail;
  logic [ADDR_W-1:0] arr_addr;
  logic [WORD_W-1:0] arr_wdata, arr_rdata;

  logic [WORD_W-1:0] mem     [256];
  logic [WORD_W-1:0] exp_mem [256];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prog_burst_collector u_dut (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_type(prog_type),
    .prog_data(prog_data), .prog_last(prog_last), .prog_addr(prog_addr),
    .ack(ack), .done(done), .init_busy(init_busy), .type_avail(type_avail),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata)
  );

  function automatic logic [WORD_W-1:0] fill_word(input int i);
    return WORD_W'(i * 40503 + 23) ^ 16'hF3A5;
  endfunction

  // Array model: asynchronous read, synchronous write
  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= fill_word(i);
    end else if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
    end
  end

  function automatic int exp_cycles(input bit ptype, input int n);
    return (ptype ? T_REP : T_NORM) + n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_burst(input int addr, input bit ptype, input int n, input bit use_last);
    logic [WORD_W-1:0] d [BMAX];
    int j;
    int waits;
    bit saw_ack;
    for (int i = 0; i < n; i++) begin
      prog_req  = 1'b1;
      prog_data = WORD_W'($urandom);
      d[i]      = prog_data;
      prog_type = (i == 0) ? ptype : 1'($urandom);
      prog_addr = (i == 0) ? ADDR_W'(addr) : ADDR_W'($urandom);
      prog_last = use_last && (i == n - 1);
      #1;
      waits = 0;
      while (!ack && waits < 100) begin
        @(negedge clk); #1; waits++;
      end
      chk(waits == 0, "R2 beat ack wait", waits, 0);
      @(posedge clk);
      @(negedge clk);
    end
    // keep requesting through countdown, writes and done (R4)
    prog_data = '1;
    prog_last = 1'b0;
    j = 0;
    saw_ack = 0;
    while (!done && j < 300) begin
      if (ack) saw_ack = 1;
      @(negedge clk);
      j++;
    end
    if (ack) saw_ack = 1;
    chk(!saw_ack, "R4 ack while busy", int'(saw_ack), 0);
    chk(j == exp_cycles(ptype, n), "R5 done latency", j, exp_cycles(ptype, n));
    prog_req = 1'b0;
    @(negedge clk);
    chk(!done, "R5 done pulse width", int'(done), 0);
    chk(!done && !ack, "R8 single done", int'(done), 0);
    for (int i = 0; i < n; i++) begin
      exp_mem[(addr + i) % 256] &= d[i];
      chk(mem[(addr + i) % 256] == exp_mem[(addr + i) % 256], "R6 array word",
          int'(mem[(addr + i) % 256]), int'(exp_mem[(addr + i) % 256]));
    end
    // neighbour beyond the burst untouched (R3)
    chk(mem[(addr + n) % 256] == exp_mem[(addr + n) % 256], "R3 burst extent",
        int'(mem[(addr + n) % 256]), int'(exp_mem[(addr + n) % 256]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb;
    int seed_dummy;
    seed_dummy = int'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) exp_mem[i] = fill_word(i);
    rst_n = 1'b0;
    prog_req = 1'b0; prog_type = 1'b0; prog_last = 1'b0;
    prog_data = '0; prog_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(init_busy == 1'b1, "R1 busy in reset", int'(init_busy), 1);
    rst_n = 1'b1;
    prog_req = 1'b1;
    #1;
    nb = 0;
    while (init_busy && nb < 100) begin
      chk(!ack, "R1 no ack during init", int'(ack), 0);
      @(negedge clk); #1;
      nb++;
    end
    prog_req = 1'b0;
    chk(nb == T_INIT, "R1 init length", nb, T_INIT);
    chk(type_avail == 2'b11, "R7 type_avail", int'(type_avail), 3);
    @(negedge clk);

    // Directed corners
    run_burst(10, 1'b0, 16, 1'b0);   // R3 limit without prog_last
    run_burst(40, 1'b0, 3, 1'b1);    // R3 next beat starts a new burst
    run_burst(60, 1'b1, 16, 1'b1);   // R3 limit and prog_last together
    run_burst(90, 1'b0, 15, 1'b1);   // R3 early end on prog_last
    run_burst(120, 1'b1, 1, 1'b1);   // R5 repair single word
    run_burst(10, 1'b1, 5, 1'b1);    // R6 second program clears more bits

    // Random bursts
    for (int k = 0; k < 25; k++) begin
      int n;
      bit lastf;
      n = int'($urandom_range(1, BMAX));
      lastf = (n == BMAX) ? 1'($urandom) : 1'b1;
      run_burst(int'($urandom_range(0, 239)), 1'($urandom), n, lastf);
    end
    chk(type_avail == 2'b11, "R7 type_avail end", int'(type_avail), 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule